// File: doc/BRIEF.md
# Peripheral Clock Gate Controller with Set/Clear Registers

This block holds the on/off decision for up to 64 peripheral clocks. The clocks are split into banks of 32. Software never changes a gate by read-modify-write. Instead, each bank has two write-only registers:

- In the enable register, every 1 bit turns one clock on.
- In the disable register, every 1 bit turns one clock off.

Bits written as 0 leave their clocks as they are. Two concurrent software agents can therefore change different clocks without a lock.

Each bank also has two read-only views:

- The request register holds the state that software asked for.
- The status register holds the state that has actually been applied to the gates.

The status follows the request after a fixed settling latency. This models the synchronisation into each gated domain. Software writes a request, then polls status until the bit reaches the new value.

The gate-enable outputs are taken from the applied status. They are updated only on the falling edge of the clock, so each enable changes while the clock is low, as a latch-style glitch-free gate needs. After reset, request and status both hold a parameterised mask, so that the essential clocks start running.

Top module: `pgate_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the request and status registers and `gate_en` equal the reset mask (default `64'h0000_0001_0000_0003`). Clock n maps to mask bit n.
- R2: A write to the enable register sets the request bits written as 1, one cycle after the write, and leaves the request bits written as 0 unchanged. The enable register is at offset 0x24 for bank 0 and 0x34 for bank 1.
- R3: A write to the disable register clears the request bits written as 1 and leaves the others unchanged. The disable register is at offset 0x28 for bank 0 and 0x38 for bank 1.
- R4: Clock ID n belongs to bank n/32 at bit n%32. Its gate is `gate_en[n]`.
- R5: Reading offset 0x2C (bank 0) or 0x3C (bank 1) returns the request word combinationally, in the same cycle as the address. The word includes a write made on the preceding edge.
- R6: Reading offset 0x30 (bank 0) or 0x40 (bank 1) returns the status word. Status equals the request word as it stood 3 cycles earlier, where 3 is the parameter `SETTLE_CYC`.
- R7: The enable and disable offsets read as zero. Every other offset reads as zero. A write to any offset other than the four enable and disable offsets changes nothing.
- R8: `gate_en` equals the status word. It changes only at a falling clock edge and never at a rising one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and gating clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gate_en | output | 64 | Per-clock gate enables, updated on the falling edge |

## Verification
A corrupted request bit shows up on the request readback in the very next cycle. It shows up on `gate_en` and the status readback exactly `SETTLE_CYC` cycles later. A fault in the settle pipeline, such as the wrong depth or a dropped stage, shows as status leading or trailing the request by the wrong number of cycles. A wrong bank or bit mapping shows as the wrong `gate_en` bit moving after a single write. The bench compares every cycle against a queue-based history of requests, so any such divergence is caught on the cycle it first reaches a port. It also samples `gate_en` just after each rising edge to catch an update on the wrong edge.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

  localparam int BANK_W    = 32;
  localparam int BASE_OFF  = 'h24;
  localparam int BANK_STEP = 'h10;

  // Register slots within one bank, in address order.
  localparam int SLOT_EN  = 0;
  localparam int SLOT_DIS = 1;
  localparam int SLOT_REQ = 2;
  localparam int SLOT_STS = 3;

  // Byte offset of a slot in a bank.
  function automatic int reg_off(input int bank, input int slot);
    return BASE_OFF + bank * BANK_STEP + slot * 4;
  endfunction

  // New request word after a set mask and a clear mask (clear wins).
  function automatic logic [BANK_W-1:0] apply_gate_write(
      input logic [BANK_W-1:0] cur,
      input logic [BANK_W-1:0] set_m,
      input logic [BANK_W-1:0] clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

endpackage

// File: rtl/pgate_bank.sv
module pgate_bank #(
  parameter int          W        = 32,
  parameter logic [W-1:0] RST_BITS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] req
);
  import pgate_pkg::*;

  logic [W-1:0] set_m, clr_m;
  assign set_m = set_stb ? wdata : '0;
  assign clr_m = clr_stb ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= RST_BITS;
    else        req <= apply_gate_write(req, set_m, clr_m);
  end

  // R2: bits written as 1 to the enable register are set
  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((req & $past(wdata)) == $past(wdata)));

  // R3: bits written as 1 to the disable register are cleared
  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((req & $past(wdata)) == '0));

  // R2: bits written as 0 keep their value
  assert_zero_bits_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_stb) |=> ((req & ~$past(wdata)) == ($past(req) & ~$past(wdata))));

  // R7: no strobe for this bank, no change
  assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_stb || clr_stb) |=> $stable(req));

endmodule

// File: rtl/pgate_settle.sv
module pgate_settle #(
  parameter int           W        = 32,
  parameter int           LAT      = 3,
  parameter logic [W-1:0] RST_BITS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  output logic [W-1:0] sts
);
  localparam int CW = $clog2(LAT + 1) + 1;

  logic [W-1:0] stage [LAT];

  genvar i;
  generate
    for (i = 0; i < LAT; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= RST_BITS;
          else        stage[0] <= req;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[i] <= RST_BITS;
          else        stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign sts = stage[LAT-1];

  // Checker state: cycles since the request last moved.
  logic [W-1:0]  req_seen;
  logic [CW-1:0] quiet_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen  <= RST_BITS;
      quiet_cnt <= CW'(LAT);
    end else begin
      req_seen <= req;
      if (req != req_seen)          quiet_cnt <= '0;
      else if (quiet_cnt < CW'(LAT)) quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  // R6: once the request has been still for the latency, status matches it
  assert_settled_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_cnt >= CW'(LAT - 1) && req == req_seen) |-> (sts == req));

endmodule

// File: rtl/pgate_glitchfree.sv
module pgate_glitchfree #(
  parameter int           W        = 32,
  parameter logic [W-1:0] RST_BITS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sts,
  output logic [W-1:0] gate
);
  // Captured on the falling edge: the enable moves only while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate <= RST_BITS;
    else        gate <= sts;
  end
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl #(
  parameter int                                 ADDR_W     = 8,
  parameter int                                 NUM_BANKS  = 2,
  parameter int                                 SETTLE_CYC = 3,
  parameter logic [NUM_BANKS*pgate_pkg::BANK_W-1:0] RESET_MASK = 64'h0000_0001_0000_0003
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [ADDR_W-1:0]                    bus_addr,
  input  logic                                 bus_we,
  input  logic [31:0]                          bus_wdata,
  output logic [31:0]                          bus_rdata,
  output logic [NUM_BANKS*pgate_pkg::BANK_W-1:0] gate_en
);
  import pgate_pkg::*;

  localparam int NUM_CLK = NUM_BANKS * BANK_W;

  logic [NUM_BANKS-1:0] hit_en, hit_dis, hit_req, hit_sts;
  logic [NUM_CLK-1:0]   req_all, sts_all;

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign hit_en[b]  = (int'(bus_addr) == reg_off(b, SLOT_EN));
      assign hit_dis[b] = (int'(bus_addr) == reg_off(b, SLOT_DIS));
      assign hit_req[b] = (int'(bus_addr) == reg_off(b, SLOT_REQ));
      assign hit_sts[b] = (int'(bus_addr) == reg_off(b, SLOT_STS));

      pgate_bank #(
        .W(BANK_W), .RST_BITS(RESET_MASK[b*BANK_W +: BANK_W])
      ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .set_stb(bus_we && hit_en[b]),
        .clr_stb(bus_we && hit_dis[b]),
        .wdata(bus_wdata),
        .req(req_all[b*BANK_W +: BANK_W])
      );

      pgate_settle #(
        .W(BANK_W), .LAT(SETTLE_CYC), .RST_BITS(RESET_MASK[b*BANK_W +: BANK_W])
      ) u_settle (
        .clk(clk), .rst_n(rst_n),
        .req(req_all[b*BANK_W +: BANK_W]),
        .sts(sts_all[b*BANK_W +: BANK_W])
      );

      pgate_glitchfree #(
        .W(BANK_W), .RST_BITS(RESET_MASK[b*BANK_W +: BANK_W])
      ) u_gf (
        .clk(clk), .rst_n(rst_n),
        .sts(sts_all[b*BANK_W +: BANK_W]),
        .gate(gate_en[b*BANK_W +: BANK_W])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (hit_req[k]) bus_rdata = req_all[k*BANK_W +: BANK_W];
      if (hit_sts[k]) bus_rdata = sts_all[k*BANK_W +: BANK_W];
    end
  end

  logic rd_silent;
  assign rd_silent = ~|(hit_req | hit_sts);

  // R7: write-only and undecoded offsets read as zero
  assert_rd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_silent |-> (bus_rdata == 32'h0));

endmodule

// File: tb/pgate_ctrl_bench.sv
module pgate_ctrl_bench;
  localparam int          LAT  = 3;
  localparam logic [63:0] MASK = 64'h0000_0001_0000_0003;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] gate_en;

  always #10 clk = ~clk;

  pgate_ctrl u_pgate_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gate_en(gate_en)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] req_m;
  logic [63:0] st_m;
  logic [63:0] hist[$];

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h2C:   return req_m[31:0];
      8'h3C:   return req_m[63:32];
      8'h30:   return st_m[31:0];
      8'h40:   return st_m[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  // One cycle: drive, check before the rising edge, update the model, check after it.
  task automatic cyc(input logic [7:0] a, input logic we, input logic [31:0] d,
                     input string tag);
    logic [63:0] snap;
    logic [63:0] nreq;
    bus_addr = a; bus_we = we; bus_wdata = d;
    @(negedge clk); #8;
    chk(tag, "rdata", {32'h0, bus_rdata}, {32'h0, exp_read(a)});
    chk("R8", "gate_en", gate_en, st_m);
    snap = gate_en;
    @(posedge clk);
    nreq = req_m;
    if (we) begin
      if (a == 8'h24) nreq[31:0]  = nreq[31:0]  | d;
      if (a == 8'h28) nreq[31:0]  = nreq[31:0]  & ~d;
      if (a == 8'h34) nreq[63:32] = nreq[63:32] | d;
      if (a == 8'h38) nreq[63:32] = nreq[63:32] & ~d;
    end
    req_m = nreq;
    hist.push_back(nreq);
    st_m = hist.pop_front();
    #1;
    chk("R8", "gate_en at rise", gate_en, snap);
  endtask

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    req_m = MASK; st_m = MASK;
    for (int i = 0; i < LAT; i++) hist.push_back(MASK);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "gate_en in reset", gate_en, MASK);
    rst_n = 1'b1;

    cyc(8'h2C, 0, 0, "R1"); cyc(8'h30, 0, 0, "R1");
    cyc(8'h3C, 0, 0, "R1"); cyc(8'h40, 0, 0, "R1");

    cyc(8'h24, 1, 32'h0000_0F00, "R2");
    cyc(8'h2C, 0, 0, "R5");
    for (int i = 0; i < 4; i++) cyc(8'h30, 0, 0, "R6");
    cyc(8'h24, 1, 32'h0, "R2");
    cyc(8'h2C, 0, 0, "R2");

    cyc(8'h28, 1, 32'h0000_0301, "R3");
    cyc(8'h2C, 0, 0, "R3");
    for (int i = 0; i < 4; i++) cyc(8'h30, 0, 0, "R6");

    // Clock ID 40: bank 1, bit 8
    cyc(8'h34, 1, 32'h0000_0100, "R4");
    for (int i = 0; i < 4; i++) cyc(8'h40, 0, 0, "R4");
    cyc(8'h38, 1, 32'h0000_0001, "R3");
    cyc(8'h3C, 0, 0, "R3");

    cyc(8'h24, 0, 0, "R7"); cyc(8'h28, 0, 0, "R7");
    cyc(8'h34, 0, 0, "R7"); cyc(8'h38, 0, 0, "R7");
    cyc(8'h20, 1, 32'hFFFF_FFFF, "R7"); cyc(8'h44, 1, 32'hFFFF_FFFF, "R7");
    cyc(8'h2A, 1, 32'hFFFF_FFFF, "R7"); cyc(8'h2C, 1, 32'hFFFF_FFFF, "R7");
    cyc(8'h30, 1, 32'hFFFF_FFFF, "R7");
    cyc(8'h2C, 0, 0, "R7"); cyc(8'h3C, 0, 0, "R7");

    cyc(8'h24, 1, 32'h00F0_0000, "R6");
    cyc(8'h28, 1, 32'h00F0_0000, "R6");
    for (int i = 0; i < 5; i++) cyc(8'h30, 0, 0, "R6");

    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:1])
        3'd0: a = 8'h24; 3'd1: a = 8'h28; 3'd2: a = 8'h34; 3'd3: a = 8'h38;
        3'd4: a = 8'h30; 3'd5: a = 8'h40; 3'd6: a = 8'h2C; default: a = 8'h3C;
      endcase
      cyc(a, lfsr[0], lfsr ^ {lfsr[15:0], lfsr[31:16]}, "R6");
    end
    for (int i = 0; i < 4; i++) begin
      cyc(8'h30, 0, 0, "R6");
      cyc(8'h40, 0, 0, "R6");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule